// File: doc/BRIEF.md
# Grouped Priority Interrupt Collector

This block gathers up to 32 single-bit interrupt request lines into a 32-bit pending register and keeps a 32-bit suppression (mask) register beside it. Both registers sit behind a small word-addressed register bus. Each request line owns the pending bit at its own index. A set mask bit stops that line from changing its pending bit. The block also takes a control-register write from a disk-controller DMA path that can force one pending bit directly.

Pending bits fall into three fixed groups, and each group maps to one processor priority level. Bits 28 to 31 map to level 6, bits 16 and 17 map to level 5, and bits 0 to 11 map to level 3. The block drives a 3-bit level output to the CPU. That output is the highest level whose group has a pending bit set. A CPU model, vector generation and acknowledge cycles are outside the block.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, the pending register, the mask register, `rdata_o` and `level_o` are all zero.
- R2: A line that is high and not masked at a clock edge has its pending bit at 1 after that edge. The bit is set again at every such edge.
- R3: A line whose mask bit is 1 never sets its pending bit.
- R4: A line that was high at the previous edge, is low at this edge and is not masked has its pending bit cleared after this edge.
- R5: `level_o` is 6 when any of pending bits 28..31 is set. Otherwise it is 5 when bit 16 or 17 is set. Otherwise it is 3 when any of bits 0..11 is set. Otherwise it is 0. Pending bits 12..15, 18..27 do not affect the level.
- R6: A bus write to offset 2 copies bit 4 of the write data into pending bit 26. All other bits of that write are ignored.
- R7: A bus write to offset 0 replaces the whole pending register. A line that is still high and unmasked sets its bit again at the following edge.
- R8: A bus write to offset 1 loads the mask register, and a read of offset 1 returns it.
- R9: A read is accepted at a clock edge. `rdata_o` then shows the addressed register as it was just before that edge. Reads of offsets 2 and 3 return 0, and writes to offset 3 change nothing.
- R10: In the edge of a bus write, the written value wins over the request lines. For offset 0 this holds for the whole register. For offset 2 it holds for bit 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Request lines, one per pending bit |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word offset: 0 pending, 1 mask, 2 DMA control, 3 unused |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read |
| level_o | output | 3 | Requested priority level (0, 3, 5 or 6) |

## Verification
Pending and mask bits change at the edge that samples a line change or a bus write. `level_o` follows combinationally, so it is due right after that edge. Read data lags by one edge and holds the value from before the accepting edge. The bench drives inputs on the falling edge and checks `level_o` at the next falling edge. It queues each read's expected word and compares it 5 ns after the accepting rising edge. The back-to-back write-then-read sequences rely on that pre-edge snapshot to see the write winning before a held line sets its bit again.

// File: rtl/irq_level_ctrl_pkg.sv
package irq_level_ctrl_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 2;
  localparam int unsigned LW = 3;
  typedef logic [DW-1:0] word_t;
  typedef enum logic [AW-1:0] {
    OFS_PEND  = 2'd0,
    OFS_MASK  = 2'd1,
    OFS_DMACT = 2'd2,
    OFS_RSVD  = 2'd3
  } ofs_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_level_ctrl_pkg::*;
(
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic          wr_pend_o,
  output logic          wr_mask_o,
  output logic          wr_dmact_o,
  output logic          rd_o
);
  logic wr;
  assign wr         = req_i & we_i;
  assign wr_pend_o  = wr && (addr_i == OFS_PEND);
  assign wr_mask_o  = wr && (addr_i == OFS_MASK);
  assign wr_dmact_o = wr && (addr_i == OFS_DMACT);
  assign rd_o       = req_i & ~we_i;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned DW        = 32,
  parameter int unsigned FORCE_BIT = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] mask_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          force_wr_i,
  input  logic          force_val_i,
  output logic [DW-1:0] pend_o
);
  logic [DW-1:0] src_q, pend_q, pend_d, set_v, clr_v;

  assign set_v = src_i & ~mask_i;
  assign clr_v = src_q & ~src_i & ~mask_i;

  always_comb begin
    pend_d = (pend_q | set_v) & ~clr_v;
    if (force_wr_i) pend_d[FORCE_BIT] = force_val_i;
    if (wr_i) pend_d = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LW    = 3,
  parameter int unsigned GRP_N = 3,
  parameter logic [GRP_N-1:0][DW-1:0] GRP_MASK = '0,
  parameter logic [GRP_N-1:0][LW-1:0] GRP_LVL  = '0
) (
  input  logic [DW-1:0] pend_i,
  output logic [LW-1:0] level_o
);
  logic [GRP_N-1:0] hit;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign hit[g] = |(pend_i & GRP_MASK[g]);
  end

  always_comb begin
    logic [LW-1:0] best;
    best = '0;
    for (int g = 0; g < GRP_N; g++) begin
      if (hit[g] && (GRP_LVL[g] > best)) best = GRP_LVL[g];
    end
    level_o = best;
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_level_ctrl_pkg::*;
#(
  parameter logic [DW-1:0] HI_MASK   = 32'hF000_0000,
  parameter logic [DW-1:0] MID_MASK  = 32'h0003_0000,
  parameter logic [DW-1:0] LO_MASK   = 32'h0000_0FFF,
  parameter logic [LW-1:0] HI_LVL    = 3'd6,
  parameter logic [LW-1:0] MID_LVL   = 3'd5,
  parameter logic [LW-1:0] LO_LVL    = 3'd3,
  parameter int unsigned   FORCE_BIT = 26,
  parameter int unsigned   DMAEN_BIT = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] irq_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o
);
  localparam int unsigned GRP_N = 3;
  localparam logic [GRP_N-1:0][DW-1:0] GRP_MASK = {HI_MASK, MID_MASK, LO_MASK};
  localparam logic [GRP_N-1:0][LW-1:0] GRP_LVL  = {HI_LVL, MID_LVL, LO_LVL};

  logic  wr_pend, wr_mask, wr_dmact, rd;
  word_t pend_q, mask_q, rdata_q;

  irq_bus_decode u_dec (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wr_pend_o  (wr_pend),
    .wr_mask_o  (wr_mask),
    .wr_dmact_o (wr_dmact),
    .rd_o       (rd)
  );

  irq_pend_reg #(.DW(DW), .FORCE_BIT(FORCE_BIT)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (irq_i),
    .mask_i      (mask_q),
    .wr_i        (wr_pend),
    .wdata_i     (wdata_i),
    .force_wr_i  (wr_dmact),
    .force_val_i (wdata_i[DMAEN_BIT]),
    .pend_o      (pend_q)
  );

  irq_level_enc #(
    .DW(DW), .LW(LW), .GRP_N(GRP_N), .GRP_MASK(GRP_MASK), .GRP_LVL(GRP_LVL)
  ) u_lvl (
    .pend_i  (pend_q),
    .level_o (level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata_i;
      if (rd) begin
        unique case (addr_i)
          OFS_PEND: rdata_q <= pend_q;
          OFS_MASK: rdata_q <= mask_q;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_level_ctrl_pkg::*;
#(
  parameter logic [DW-1:0] HI_MASK   = 32'hF000_0000,
  parameter logic [DW-1:0] MID_MASK  = 32'h0003_0000,
  parameter logic [DW-1:0] LO_MASK   = 32'h0000_0FFF,
  parameter logic [LW-1:0] HI_LVL    = 3'd6,
  parameter int unsigned   FORCE_BIT = 26,
  parameter int unsigned   DMAEN_BIT = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] irq_i,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [LW-1:0] level_o,
  input logic [DW-1:0] pend_q,
  input logic [DW-1:0] mask_q
);
  logic [DW-1:0] prev_q;
  logic wr;
  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= irq_i;
  end

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> ((~pend_q & $past(irq_i & ~mask_q)) == '0));

  p_mask_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> (((pend_q & ~$past(pend_q)) & ~$past(irq_i & ~mask_q)) == '0));

  p_fall_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && (|(prev_q & ~irq_i & ~mask_q)))
      |=> ((pend_q & $past(prev_q & ~irq_i & ~mask_q)) == '0));

  p_lvl_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & (HI_MASK | MID_MASK | LO_MASK)) == '0) |-> (level_o == '0));

  p_lvl_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_q & HI_MASK)) |-> (level_o == HI_LVL));

  p_force_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DMACT) |=> (pend_q[FORCE_BIT] == $past(wdata_i[DMAEN_BIT])));

  p_pend_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_PEND) |=> (pend_q == $past(wdata_i)));

  p_mask_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_MASK) |=> (mask_q == $past(wdata_i)));

  p_mask_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && addr_i == OFS_MASK) |=> $stable(mask_q));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
  .HI_MASK(HI_MASK), .MID_MASK(MID_MASK), .LO_MASK(LO_MASK),
  .HI_LVL(HI_LVL), .FORCE_BIT(FORCE_BIT), .DMAEN_BIT(DMAEN_BIT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_i   (irq_i),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .level_o (level_o),
  .pend_q  (pend_q),
  .mask_q  (mask_q)
);

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [2:0]  level_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  irq_level_ctrl u_irq_level_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .level_o(level_o)
  );

  // monitor: compare read data after the accepting edge
  always @(posedge clk) begin
    bit fire;
    fire = rst_ni && req_i && !we_i;
    #5;
    if (fire) begin
      item_t it;
      it = sb_q.pop_front();
      total++;
      if (rdata_o !== it.exp) begin
        bad++;
        $display("FAIL %s: rdata got %h exp %h", it.tag, rdata_o, it.exp);
      end
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic chk_lvl(input logic [2:0] exp, input string tag);
    chk({29'd0, level_o}, {29'd0, exp}, tag);
  endtask

  task automatic set_irq(input logic [31:0] v);
    irq_i = v;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk);
    req_i = 0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk_lvl(0, "R1 level");
    chk(rdata_o, 0, "R1 rdata");
    rd(0, 32'h0, "R1 pend");
    rd(1, 32'h0, "R1 mask");

    set_irq(32'h0000_0008);
    chk_lvl(3, "R5 lo");
    rd(0, 32'h0000_0008, "R2 set");
    set_irq(32'h0002_0008);
    chk_lvl(5, "R5 mid");
    set_irq(32'h2002_0008);
    chk_lvl(6, "R5 hi");
    rd(0, 32'h2002_0008, "R2 three");
    set_irq(32'h0002_0008);
    chk_lvl(5, "R4 hi fall");
    rd(0, 32'h0002_0008, "R4 one cleared");
    set_irq(32'h0);
    chk_lvl(0, "R4 all fall");
    rd(0, 32'h0, "R4 empty");

    wr(1, 32'h1000_0000);
    rd(1, 32'h1000_0000, "R8 mask");
    set_irq(32'h1000_0000);
    chk_lvl(0, "R3 masked level");
    rd(0, 32'h0, "R3 masked pend");
    set_irq(32'h0400_0000);
    chk_lvl(0, "R5 bit26 no level");
    rd(0, 32'h0400_0000, "R5 bit26 pend");
    set_irq(32'h0);
    rd(0, 32'h0, "R4 bit26 fall");

    wr(2, 32'h0000_0010);
    chk_lvl(0, "R6 force level");
    rd(0, 32'h0400_0000, "R6 force set");
    wr(2, 32'hFFFF_FFEF);
    rd(0, 32'h0, "R6 force clr");

    wr(1, 32'h0);
    set_irq(32'h0000_0020);
    wr(0, 32'h0000_0100);
    rd(0, 32'h0000_0100, "R10 pend write wins");
    rd(0, 32'h0000_0120, "R7 reassert");
    chk_lvl(3, "R7 level");
    wr(0, 32'h0);
    set_irq(32'h0);
    rd(0, 32'h0, "R7 cleared");

    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h0, "R9 rsvd read");
    rd(2, 32'h0, "R9 ctl read");
    rd(0, 32'h0, "R9 pend untouched");
    rd(1, 32'h0, "R9 mask untouched");

    set_irq(32'h0400_0000);
    wr(2, 32'h0);
    rd(0, 32'h0, "R10 ctl wins");
    rd(0, 32'h0400_0000, "R10 line resets");
    set_irq(32'h0);

    set_irq(32'h0001_0001);
    chk_lvl(5, "R5 mid over lo");
    set_irq(32'h0000_1000);
    chk_lvl(0, "R5 bit12 ungrouped");
    set_irq(32'h8000_0800);
    chk_lvl(6, "R5 hi over lo");
    set_irq(32'h0);
    chk_lvl(0, "R5 back to idle");

    repeat (2) @(negedge clk);
    done = 1;
    report();
  end
endmodule